// File: doc/BRIEF.md
# Ethernet Receive Frame Status Checker

This block watches one received Ethernet frame at a time. The frame arrives as a stream of 4-bit nibbles, least significant nibble of each byte first, with the preamble already stripped, so the first nibble carries the low bits of the first destination-address byte. A one-cycle `frm_start` strobe opens the frame and a one-cycle `frm_end` strobe closes it. While the frame streams in, the block counts its length and notes any overrun or buffer-full indication. At frame end it combines these with an external CRC verdict.

One cycle after `frm_end`, the block gives an 8-bit status byte, an accept/reject decision and interrupt pulses. The status byte stays readable on `last_status` until the next frame ends. Bit positions are fixed: bit 0 buffer full, bit 1 CRC error, bit 2 alignment error, bit 3 FIFO overrun, bit 4 watchdog, bit 5 multicast, bit 6 runt, bit 7 receive error.

Top module: `rx_frame_status`

## Requirements
- R1: After reset, `stat_valid`, `last_status`, `frm_accept`, `irq_rx` and `irq_err` are all 0.
- R2: `stat_valid` is high for exactly the one cycle after the cycle in which `frm_end` is high. `last_status` takes the new byte in that same cycle and then keeps it until the next frame end.
- R3: Bit 0 is 1 when `buf_full` was high in any cycle from `frm_start` through `frm_end`.
- R4: Bit 1 is the inverse of `crc_ok` as sampled in the `frm_end` cycle.
- R5: Bit 2 is 1 when the frame held an odd number of nibbles. The CRC result does not affect it.
- R6: Bit 3 is 1 when `fifo_ovr` was high in any cycle of the frame.
- R7: Bit 4 is 1 when the byte length (nibble count divided by 2, rounded down) exceeds 2048. The length count saturates, so longer frames cannot wrap it.
- R8: Bit 5 copies bit 0 of the first nibble of the frame. A frame with no nibbles has bit 5 equal to 0.
- R9: Bit 6 is 1 when the byte length is below 64 with `runt_sel`=0, or below 60 with `runt_sel`=1. `runt_sel` is sampled at `frm_end`.
- R10: Bit 7 is the OR of bits 1, 2, 3 and 4.
- R11: `frm_accept` is 1 exactly when bit 0 is 0 and either `pass_bad`=1 or both bit 7 and bit 6 are 0. `pass_bad` is sampled at `frm_end`. `irq_rx` pulses with `stat_valid` when the frame is accepted.
- R12: `irq_err` pulses with `stat_valid` when bit 3 or bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | One-cycle strobe that opens a frame |
| nib_valid | input | 1 | A nibble is present on nib_data |
| nib_data | input | 4 | Received nibble, low nibble of each byte first |
| frm_end | input | 1 | One-cycle strobe that closes the frame |
| crc_ok | input | 1 | CRC verdict from the external checker, valid at frm_end |
| fifo_ovr | input | 1 | RX FIFO overrun indication |
| buf_full | input | 1 | Packet buffer full indication |
| pass_bad | input | 1 | Accept errored and runt frames |
| runt_sel | input | 1 | 1: runt limit 60 bytes, 0: 64 bytes |
| stat_valid | output | 1 | Status and decision valid this cycle |
| last_status | output | 8 | Status byte of the last finished frame |
| frm_accept | output | 1 | Accept decision, qualified by stat_valid |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Overrun or watchdog interrupt pulse |

## Verification
The length logic is tested with frames of 119, 120, 127 and 128 nibbles under both runt limits. This separates the two thresholds from each other, and it separates the odd-nibble flag from the byte count. Frames of exactly 2048 and 2049 bytes show where the watchdog trips. Random frames vary the CRC verdict, the timing of overrun and buffer-full pulses, the first-nibble multicast bit and pass-bad together, so the OR term and the accept rule are tested in combinations that each input alone would not reach. After every frame the status byte is read again one cycle later, which shows it is held.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   typedef struct packed {
      logic rerr;
      logic runt;
      logic mcast;
      logic wdog;
      logic ovr;
      logic align;
      logic crc_err;
      logic full;
   } rxs_status_t;
endpackage

// File: rtl/rxs_len_count.sv
module rxs_len_count #(
   parameter int MAX_BYTES  = 2048,
   parameter int RUNT_LONG  = 64,
   parameter int RUNT_SHORT = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic nib_valid,
   input  logic runt_sel,
   output logic odd,
   output logic giant,
   output logic runt
);
   localparam int SAT_NIBS = 2 * MAX_BYTES + 2;
   localparam int CNT_W    = $clog2(SAT_NIBS + 1);

   logic [CNT_W-1:0] nib_cnt;
   logic             parity;
   logic [CNT_W-2:0] byte_cnt;
   logic [CNT_W-2:0] thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nib_cnt <= '0;
         parity  <= 1'b0;
      end else if (clr) begin
         nib_cnt <= '0;
         parity  <= 1'b0;
      end else if (nib_valid) begin
         parity <= ~parity;
         if (nib_cnt != CNT_W'(SAT_NIBS))
            nib_cnt <= nib_cnt + 1'b1;
      end
   end

   assign byte_cnt = nib_cnt[CNT_W-1:1];
   assign thr      = runt_sel ? (CNT_W-1)'(RUNT_SHORT) : (CNT_W-1)'(RUNT_LONG);
   assign odd      = parity;
   assign giant    = nib_cnt >= CNT_W'(SAT_NIBS);
   assign runt     = byte_cnt < thr;
endmodule

// File: rtl/rxs_first_nib.sv
module rxs_first_nib (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       nib_valid,
   input  logic [3:0] nib_data,
   output logic       mcast
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         mcast   <= 1'b0;
      end else if (clr) begin
         pending <= 1'b1;
         mcast   <= 1'b0;
      end else if (nib_valid && pending) begin
         pending <= 1'b0;
         mcast   <= nib_data[0];
      end
   end
endmodule

// File: rtl/rxs_status_reg.sv
module rxs_status_reg
   import rxs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        frm_end,
   input  logic        crc_ok,
   input  logic        fifo_ovr,
   input  logic        buf_full,
   input  logic        pass_bad,
   input  logic        odd,
   input  logic        giant,
   input  logic        runt,
   input  logic        mcast,
   output logic        stat_valid,
   output rxs_status_t status_q,
   output logic        accept_q,
   output logic        irq_rx_q,
   output logic        irq_err_q
);
   logic        ovr_seen, full_seen;
   rxs_status_t st_d;
   logic        acc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_seen  <= 1'b0;
         full_seen <= 1'b0;
      end else if (clr) begin
         ovr_seen  <= fifo_ovr;
         full_seen <= buf_full;
      end else begin
         if (fifo_ovr) ovr_seen  <= 1'b1;
         if (buf_full) full_seen <= 1'b1;
      end
   end

   always_comb begin
      st_d.full    = full_seen | buf_full;
      st_d.crc_err = ~crc_ok;
      st_d.align   = odd;
      st_d.ovr     = ovr_seen | fifo_ovr;
      st_d.wdog    = giant;
      st_d.mcast   = mcast;
      st_d.runt    = runt;
      st_d.rerr    = st_d.crc_err | st_d.align | st_d.ovr | st_d.wdog;
      acc_d        = ~st_d.full & (pass_bad | (~st_d.rerr & ~st_d.runt));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_valid <= 1'b0;
         status_q   <= '0;
         accept_q   <= 1'b0;
         irq_rx_q   <= 1'b0;
         irq_err_q  <= 1'b0;
      end else begin
         stat_valid <= frm_end;
         accept_q   <= frm_end & acc_d;
         irq_rx_q   <= frm_end & acc_d;
         irq_err_q  <= frm_end & (st_d.ovr | st_d.wdog);
         if (frm_end) status_q <= st_d;
      end
   end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
   import rxs_pkg::*;
#(
   parameter int MAX_BYTES  = 2048,
   parameter int RUNT_LONG  = 64,
   parameter int RUNT_SHORT = 60,
   parameter bit MCAST_EN   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frm_start,
   input  logic       nib_valid,
   input  logic [3:0] nib_data,
   input  logic       frm_end,
   input  logic       crc_ok,
   input  logic       fifo_ovr,
   input  logic       buf_full,
   input  logic       pass_bad,
   input  logic       runt_sel,
   output logic       stat_valid,
   output logic [7:0] last_status,
   output logic       frm_accept,
   output logic       irq_rx,
   output logic       irq_err
);
   logic        odd, giant, runt, mcast;
   rxs_status_t st_q;

   if (RUNT_SHORT > RUNT_LONG) begin : g_bad_runt
      $error("RUNT_SHORT must not exceed RUNT_LONG");
   end
   if (MAX_BYTES <= RUNT_LONG) begin : g_bad_max
      $error("MAX_BYTES must exceed RUNT_LONG");
   end

   rxs_len_count #(
      .MAX_BYTES (MAX_BYTES),
      .RUNT_LONG (RUNT_LONG),
      .RUNT_SHORT(RUNT_SHORT)
   ) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frm_start),
      .nib_valid(nib_valid),
      .runt_sel (runt_sel),
      .odd      (odd),
      .giant    (giant),
      .runt     (runt)
   );

   if (MCAST_EN) begin : g_mcast
      rxs_first_nib u_first (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (frm_start),
         .nib_valid(nib_valid),
         .nib_data (nib_data),
         .mcast    (mcast)
      );
   end else begin : g_no_mcast
      assign mcast = 1'b0;
   end

   rxs_status_reg u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (frm_start),
      .frm_end   (frm_end),
      .crc_ok    (crc_ok),
      .fifo_ovr  (fifo_ovr),
      .buf_full  (buf_full),
      .pass_bad  (pass_bad),
      .odd       (odd),
      .giant     (giant),
      .runt      (runt),
      .mcast     (mcast),
      .stat_valid(stat_valid),
      .status_q  (st_q),
      .accept_q  (frm_accept),
      .irq_rx_q  (irq_rx),
      .irq_err_q (irq_err)
   );

   assign last_status = st_q;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_end,
   input logic       crc_ok,
   input logic       buf_full,
   input logic       stat_valid,
   input logic [7:0] last_status,
   input logic       frm_accept,
   input logic       irq_rx,
   input logic       irq_err
);
   a_r2_valid_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
      frm_end |=> stat_valid);
   a_r2_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_end |=> $stable(last_status));
   a_r3_full_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_end && buf_full) |=> last_status[0]);
   a_r4_crc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      frm_end |=> (last_status[1] == !$past(crc_ok)));
   a_r11_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && last_status[0]) |-> !frm_accept);
   a_r11_irq_rx_accept: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (stat_valid && frm_accept));
   a_r12_irq_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (stat_valid && (last_status[3] || last_status[4])));
endmodule

bind rx_frame_status rxs_checker u_rxs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_end    (frm_end),
   .crc_ok     (crc_ok),
   .buf_full   (buf_full),
   .stat_valid (stat_valid),
   .last_status(last_status),
   .frm_accept (frm_accept),
   .irq_rx     (irq_rx),
   .irq_err    (irq_err)
);

// File: tb/rx_frame_status_bench.sv
module rx_frame_status_bench;
   localparam time CYC = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_start = 1'b0, nib_valid = 1'b0, frm_end = 1'b0;
   logic [3:0] nib_data = '0;
   logic       crc_ok = 1'b0, fifo_ovr = 1'b0, buf_full = 1'b0;
   logic       pass_bad = 1'b0, runt_sel = 1'b0;
   logic       stat_valid, frm_accept, irq_rx, irq_err;
   logic [7:0] last_status;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CYC/2) clk = ~clk;

   rx_frame_status u_rx_frame_status (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .nib_valid(nib_valid),
      .nib_data(nib_data), .frm_end(frm_end), .crc_ok(crc_ok), .fifo_ovr(fifo_ovr),
      .buf_full(buf_full), .pass_bad(pass_bad), .runt_sel(runt_sel),
      .stat_valid(stat_valid), .last_status(last_status), .frm_accept(frm_accept),
      .irq_rx(irq_rx), .irq_err(irq_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(int nibs, bit mc, bit crc, bit ovr,
                                             bit full, bit sel);
      logic [7:0] s;
      int bytes;
      bytes = nibs / 2;
      s[0] = full;
      s[1] = !crc;
      s[2] = nibs % 2;
      s[3] = ovr;
      s[4] = bytes > 2048;
      s[5] = (nibs > 0) ? mc : 1'b0;
      s[6] = bytes < (sel ? 60 : 64);
      s[7] = s[1] | s[2] | s[3] | s[4];
      return s;
   endfunction

   function automatic bit exp_accept(logic [7:0] s, bit pb);
      return !s[0] && (pb || (!s[7] && !s[6]));
   endfunction

   // ovr_at / full_at: nibble index carrying the pulse, -1 for none
   task automatic run_frame(int nibs, bit mc, bit crc, int ovr_at, int full_at,
                            bit pb, bit sel);
      logic [7:0] es;
      bit ea;
      string tags[8];
      tags = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};
      es = exp_status(nibs, mc, crc, (ovr_at >= 0) && (ovr_at < nibs),
                      (full_at >= 0) && (full_at < nibs), sel);
      ea = exp_accept(es, pb);
      @(negedge clk) frm_start = 1'b1;
      @(negedge clk) frm_start = 1'b0;
      for (int i = 0; i < nibs; i++) begin
         nib_valid = 1'b1;
         nib_data  = (i == 0) ? {3'($urandom), mc} : 4'($urandom);
         fifo_ovr  = (i == ovr_at);
         buf_full  = (i == full_at);
         @(negedge clk);
      end
      nib_valid = 1'b0; fifo_ovr = 1'b0; buf_full = 1'b0;
      frm_end = 1'b1; crc_ok = crc; pass_bad = pb; runt_sel = sel;
      @(negedge clk) frm_end = 1'b0;
      crc_ok = !crc; pass_bad = !pb; runt_sel = !sel;
      check(stat_valid === 1'b1, "R2", stat_valid, 1);
      for (int b = 0; b < 8; b++)
         check(last_status[b] === es[b], tags[b], last_status[b], es[b]);
      check(frm_accept === ea, "R11", frm_accept, ea);
      check(irq_rx === ea, "R11", irq_rx, ea);
      check(irq_err === (es[3] | es[4]), "R12", irq_err, es[3] | es[4]);
      @(negedge clk);
      check(stat_valid === 1'b0 && last_status === es, "R2", last_status, es);
      check(irq_rx === 1'b0 && irq_err === 1'b0, "R12", {irq_rx, irq_err}, 0);
   endtask

   initial begin
      #(CYC * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      #(CYC * 3);
      @(negedge clk);
      check(stat_valid === 0 && last_status === 8'h00 && frm_accept === 0
            && irq_rx === 0 && irq_err === 0, "R1", last_status, 0);
      rst_n = 1'b1;
      // runt boundaries (R9) and odd nibble (R5)
      run_frame(119, 1'b0, 1'b1, -1, -1, 1'b0, 1'b1);
      run_frame(120, 1'b0, 1'b1, -1, -1, 1'b0, 1'b1);
      run_frame(120, 1'b0, 1'b1, -1, -1, 1'b0, 1'b0);
      run_frame(127, 1'b1, 1'b1, -1, -1, 1'b0, 1'b0);
      run_frame(128, 1'b1, 1'b1, -1, -1, 1'b0, 1'b0);
      // runt accepted with pass-bad (R11)
      run_frame(100, 1'b0, 1'b1, -1, -1, 1'b1, 1'b0);
      // watchdog edges (R7)
      run_frame(4096, 1'b0, 1'b1, -1, -1, 1'b0, 1'b0);
      run_frame(4098, 1'b0, 1'b1, -1, -1, 1'b1, 1'b0);
      run_frame(4400, 1'b1, 1'b1, -1, -1, 1'b0, 1'b0);
      // overrun and full (R6, R3), empty frame (R8)
      run_frame(200, 1'b1, 1'b1, 0, -1, 1'b1, 1'b0);
      run_frame(200, 1'b0, 1'b1, -1, 199, 1'b1, 1'b0);
      run_frame(0, 1'b1, 1'b1, -1, -1, 1'b1, 1'b1);
      for (int k = 0; k < 60; k++) begin
         int n;
         n = 100 + int'($urandom_range(0, 300));
         run_frame(n, 1'($urandom), ($urandom_range(0, 3) != 0),
                   ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, n - 1)) : -1,
                   ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, n - 1)) : -1,
                   1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule